// File: doc/BRIEF.md
# Lottery Bus Arbiter

This block decides which of several masters on a shared bus owns it. Every master holds a count of lottery tickets. When the bus is free and at least one master requests it, the arbiter draws a pseudo-random number, reduces it modulo the total tickets held by the masters that are requesting at that moment, and hands the bus to the master whose slice of that total contains the number. Over many grants, each master's share of the bus follows its share of the active tickets. A low-ticket master is never starved the way it can be under fixed priority, and no one waits for a fixed time slot.

Once a master wins, it keeps the bus for as long as it holds its request, whatever the other masters do. The next draw happens only when the owner lets go. Ticket counts come either from a build-time constant or, in the run-time variant, from registers that a configuration port writes one master at a time. The outputs are a one-hot grant and a grant-valid flag.

Top module: `lotteryArbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `grant` is all zeros and `grantValid` is low.
- R2: `grant` has at most one bit set, bit i naming master i. `grantValid` is high exactly when a bit of `grant` is set. A new grant appears on the clock edge after the request that produced it.
- R3: If no master requests at a clock edge, `grant` is zero and `grantValid` is low after that edge.
- R4: A grant only goes to a master that requested at the preceding edge. When a requesting master with a nonzero ticket count exists, a master with zero tickets never wins.
- R5: A sole requester wins the draw whatever its ticket count, zero included.
- R6: When every requester holds zero tickets, the requester with the lowest index wins.
- R7: While the owning master keeps its request high, `grant` does not change, whatever the other request bits do.
- R8: When the owner drops its request while other masters request, a new draw among those masters is made at that edge, so the grant moves to one of them in the next cycle.
- R9: Over repeated draws between two masters with 1 and 3 tickets, the 3-ticket master wins roughly three quarters of the time (between 55% and 95% of 200 draws).
- R10: In the run-time variant (`DYNAMIC_TICKETS`=1), reset loads `INIT_TICKETS` (4 bits per master, master 0 in the low bits). A clock edge with `cfgWrEn` high stores `cfgTickets` as the count of master `cfgIdx`, and that count is used from the next draw on.
- R11: In the build-time variant (`DYNAMIC_TICKETS`=0), the counts are always `INIT_TICKETS`, and configuration writes have no effect on the draws.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NUM_MASTERS | Bus request, one bit per master |
| cfgWrEn | input | 1 | Write strobe for a ticket count |
| cfgIdx | input | $clog2(NUM_MASTERS) | Master whose count is written |
| cfgTickets | input | TICKET_W | Ticket count to store |
| grant | output | NUM_MASTERS | One-hot bus grant |
| grantValid | output | 1 | High while some master holds the bus |

## Verification
The weighted part of the draw is the hardest thing to observe at the ports. A single random outcome proves nothing, and the bench cannot predict the generator without copying it. The stimulus therefore programs known ticket counts through the configuration port and repeats the request-and-release cycle hundreds of times, then checks the win counts against a loose band. It also builds the deterministic corners on purpose: it zeroes counts so that only one outcome is legal, and it runs a build-time instance next to the run-time one so that the effect of a configuration write becomes visible.

// File: rtl/lotteryPkg.sv
package lotteryPkg;

  // Strobes from control to datapath for one clock edge
  typedef struct packed {
    logic draw;   // load a fresh lottery winner into the grant register
    logic clear;  // release the bus with no new owner
  } ctrlStrobes_t;

  typedef enum logic [0:0] {
    ARB_FREE  = 1'b0,
    ARB_OWNED = 1'b1
  } arbState_t;

endpackage

// File: rtl/lotteryTicketStore.sv
module lotteryTicketStore #(
  parameter int NUM_MASTERS = 4,
  parameter int TICKET_W = 4,
  parameter bit DYNAMIC_TICKETS = 1'b1,
  parameter logic [NUM_MASTERS*TICKET_W-1:0] INIT_TICKETS = 16'h4321,
  localparam int IDX_W = $clog2(NUM_MASTERS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfgWrEn,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [TICKET_W-1:0] cfgTickets,
  output logic [NUM_MASTERS-1:0][TICKET_W-1:0] tickets
);

  generate
    if (DYNAMIC_TICKETS) begin : gDynamic
      logic [NUM_MASTERS-1:0][TICKET_W-1:0] ticketReg;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ticketReg <= INIT_TICKETS;
        end else if (cfgWrEn) begin
          for (int i = 0; i < NUM_MASTERS; i++) begin
            if (cfgIdx == IDX_W'(i)) ticketReg[i] <= cfgTickets;
          end
        end
      end

      assign tickets = ticketReg;
    end else begin : gStatic
      // Counts are wired constants; the configuration inputs go nowhere.
      logic unusedCfg;
      assign unusedCfg = ^{clk, rst_n, cfgWrEn, cfgIdx, cfgTickets};
      assign tickets = INIT_TICKETS;
    end
  endgenerate

endmodule

// File: rtl/lotteryDatapath.sv
module lotteryDatapath
  import lotteryPkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int TICKET_W = 4,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  localparam int SUM_W = TICKET_W + $clog2(NUM_MASTERS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic [NUM_MASTERS-1:0][TICKET_W-1:0] tickets,
  input  ctrlStrobes_t strobes,
  output logic [NUM_MASTERS-1:0] grant,
  output logic ownerReq
);

  logic [LFSR_W-1:0] lfsr;
  logic [SUM_W-1:0] activeTotal;
  logic [SUM_W-1:0] drawVal;
  logic [LFSR_W-1:0] modVal;
  logic [NUM_MASTERS-1:0] weightedWin;
  logic [NUM_MASTERS-1:0] lowestReq;
  logic [NUM_MASTERS-1:0] winner;

  // Galois LFSR, stepped every cycle so that request timing adds entropy
  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= LFSR_SEED;
    else        lfsr <= (lfsr >> 1) ^ (lfsr[0] ? LFSR_TAPS : '0);
  end

  // Ticket total of the masters requesting now
  always_comb begin
    activeTotal = '0;
    for (int i = 0; i < NUM_MASTERS; i++) begin
      if (req[i]) activeTotal = activeTotal + SUM_W'(tickets[i]);
    end
  end

  // Random number reduced into [0, activeTotal)
  always_comb begin
    modVal = '0;
    if (activeTotal != '0) modVal = lfsr % LFSR_W'(activeTotal);
    drawVal = SUM_W'(modVal);
  end

  // Prefix-sum walk in index order: the first slice that covers drawVal wins
  always_comb begin
    logic [SUM_W-1:0] prefix;
    logic found;
    prefix = '0;
    found = 1'b0;
    weightedWin = '0;
    for (int i = 0; i < NUM_MASTERS; i++) begin
      if (req[i] && (tickets[i] != '0)) begin
        prefix = prefix + SUM_W'(tickets[i]);
        if (!found && (drawVal < prefix)) begin
          weightedWin[i] = 1'b1;
          found = 1'b1;
        end
      end
    end
  end

  // Fallback when every requester holds zero tickets: lowest index wins
  always_comb begin
    logic seen;
    seen = 1'b0;
    lowestReq = '0;
    for (int i = 0; i < NUM_MASTERS; i++) begin
      if (req[i] && !seen) begin
        lowestReq[i] = 1'b1;
        seen = 1'b1;
      end
    end
  end

  assign winner = (activeTotal == '0) ? lowestReq : weightedWin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant <= '0;
    end else if (strobes.draw) begin
      grant <= winner;
    end else if (strobes.clear) begin
      grant <= '0;
    end
  end

  assign ownerReq = |(grant & req);

endmodule

// File: rtl/lotteryControl.sv
module lotteryControl
  import lotteryPkg::*;
#(
  parameter int NUM_MASTERS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic ownerReq,
  output ctrlStrobes_t strobes,
  output logic busOwned
);

  arbState_t state;
  arbState_t stateNext;
  logic anyReq;

  assign anyReq = |req;

  always_comb begin
    strobes = '0;
    stateNext = state;
    case (state)
      ARB_FREE: begin
        if (anyReq) begin
          strobes.draw = 1'b1;
          stateNext = ARB_OWNED;
        end
      end
      ARB_OWNED: begin
        if (!ownerReq) begin
          if (anyReq) begin
            strobes.draw = 1'b1;
          end else begin
            strobes.clear = 1'b1;
            stateNext = ARB_FREE;
          end
        end
      end
      default: stateNext = ARB_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ARB_FREE;
    else        state <= stateNext;
  end

  assign busOwned = (state == ARB_OWNED);

endmodule

// File: rtl/lotteryArbiter.sv
module lotteryArbiter
  import lotteryPkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int TICKET_W = 4,
  parameter bit DYNAMIC_TICKETS = 1'b1,
  parameter logic [NUM_MASTERS*TICKET_W-1:0] INIT_TICKETS = 16'h4321,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  localparam int IDX_W = $clog2(NUM_MASTERS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic cfgWrEn,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [TICKET_W-1:0] cfgTickets,
  output logic [NUM_MASTERS-1:0] grant,
  output logic grantValid
);

  logic [NUM_MASTERS-1:0][TICKET_W-1:0] tickets;
  ctrlStrobes_t strobes;
  logic ownerReq;

  lotteryTicketStore #(
    .NUM_MASTERS(NUM_MASTERS),
    .TICKET_W(TICKET_W),
    .DYNAMIC_TICKETS(DYNAMIC_TICKETS),
    .INIT_TICKETS(INIT_TICKETS)
  ) uStore (
    .clk(clk),
    .rst_n(rst_n),
    .cfgWrEn(cfgWrEn),
    .cfgIdx(cfgIdx),
    .cfgTickets(cfgTickets),
    .tickets(tickets)
  );

  lotteryControl #(
    .NUM_MASTERS(NUM_MASTERS)
  ) uCtrl (
    .clk(clk),
    .rst_n(rst_n),
    .req(req),
    .ownerReq(ownerReq),
    .strobes(strobes),
    .busOwned(grantValid)
  );

  lotteryDatapath #(
    .NUM_MASTERS(NUM_MASTERS),
    .TICKET_W(TICKET_W),
    .LFSR_W(LFSR_W),
    .LFSR_TAPS(LFSR_TAPS),
    .LFSR_SEED(LFSR_SEED)
  ) uData (
    .clk(clk),
    .rst_n(rst_n),
    .req(req),
    .tickets(tickets),
    .strobes(strobes),
    .grant(grant),
    .ownerReq(ownerReq)
  );

endmodule

// File: rtl/lotteryArbiterChecker.sv
module lotteryArbiterChecker #(
  parameter int NUM_MASTERS = 4
) (
  input logic clk,
  input logic rst_n,
  input logic [NUM_MASTERS-1:0] req,
  input logic [NUM_MASTERS-1:0] grant,
  input logic grantValid
);

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2

  AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    grantValid == (grant != '0)); // R2

  AST_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> ((grant & $past(req)) != '0)); // R4

  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> (grant == '0)); // R3

  AST_HOLD_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & req) != '0) |=> (grant == $past(grant))); // R7

  AST_REARBITRATE: assert property (@(posedge clk) disable iff (!rst_n)
    (grantValid && ((grant & req) == '0) && (req != '0))
      |=> ((grant != '0) && (grant != $past(grant)))); // R8

endmodule

bind lotteryArbiter lotteryArbiterChecker #(.NUM_MASTERS(NUM_MASTERS)) uChk (
  .clk(clk),
  .rst_n(rst_n),
  .req(req),
  .grant(grant),
  .grantValid(grantValid)
);

// File: tb/sim_lotteryArbiter.sv
`timescale 1ns/1ps
module sim_lotteryArbiter;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] req = '0;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgIdx = '0;
  logic [3:0] cfgTickets = '0;
  logic [3:0] grant0, grant1;
  logic gv0, gv1;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  lotteryArbiter #(.DYNAMIC_TICKETS(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx),
    .cfgTickets(cfgTickets), .grant(grant0), .grantValid(gv0));

  lotteryArbiter #(.DYNAMIC_TICKETS(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .req(req), .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx),
    .cfgTickets(cfgTickets), .grant(grant1), .grantValid(gv1));

  // {req, legal winners} with reset counts 1,2,3,4 (all nonzero)
  localparam logic [7:0] VEC [8] = '{
    {4'b0001, 4'b0001}, {4'b0010, 4'b0010}, {4'b0100, 4'b0100},
    {4'b1000, 4'b1000}, {4'b0011, 4'b0011}, {4'b1100, 4'b1100},
    {4'b1111, 4'b1111}, {4'b0000, 4'b0000}};

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] idx, input logic [3:0] t);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgIdx = idx; cfgTickets = t;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // One request-and-release cycle; returns the grants seen one edge later
  task automatic doDraw(input logic [3:0] r, output logic [3:0] g0,
                        output logic [3:0] g1, output logic v0);
    req = r;
    @(negedge clk);
    g0 = grant0; g1 = grant1; v0 = gv0;
    req = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [3:0] g0, g1, held;
    logic v0;
    int wins1, u1Zero;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(grant0 == '0 && !gv0, "R1 reset grant u0", {gv0, grant0}, 0);
    check(grant1 == '0 && !gv1, "R1 reset grant u1", {gv1, grant1}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(grant0 == '0 && !gv0, "R1 first cycle after reset", {gv0, grant0}, 0);

    // Table walk: R2 one-hot and valid, R3 none, R4 legal winner, R5 sole
    foreach (VEC[k]) begin
      doDraw(VEC[k][7:4], g0, g1, v0);
      check($onehot0(g0) && ((g0 & ~VEC[k][3:0]) == '0) && (v0 == (VEC[k][3:0] != '0))
            && ((g0 != '0) == (VEC[k][3:0] != '0)),
            "R2 R3 R4 R5 table grant", g0, VEC[k][3:0]);
    end

    // R10 and R9: counts 1 and 3, 200 draws between masters 0 and 1
    cfgWrite(2'd0, 4'd1);
    cfgWrite(2'd1, 4'd3);
    wins1 = 0;
    for (int n = 0; n < 200; n++) begin
      doDraw(4'b0011, g0, g1, v0);
      if (g0 == 4'b0010) wins1++;
    end
    check(wins1 >= 110 && wins1 <= 190, "R9 R10 share of 3-ticket master", wins1, 150);

    // R10 zero count for master 0: u0 never picks it; R11 u1 still can
    cfgWrite(2'd0, 4'd0);
    u1Zero = 0;
    for (int n = 0; n < 40; n++) begin
      doDraw(4'b0011, g0, g1, v0);
      check(g0 == 4'b0010, "R4 R10 zero-ticket master lost", g0, 4'b0010);
      if (g1 == 4'b0001) u1Zero++;
    end
    check(u1Zero > 0, "R11 static variant ignores write", u1Zero, 1);

    // R6: all requesters zero tickets -> lowest index
    cfgWrite(2'd1, 4'd0);
    doDraw(4'b0011, g0, g1, v0);
    check(g0 == 4'b0001, "R6 lowest index among zero-ticket", g0, 4'b0001);
    doDraw(4'b0110, g0, g1, v0);
    check(g0 == 4'b0100, "R4 ticket holder beats zero-ticket", g0, 4'b0100);
    // R5: sole zero-ticket requester
    doDraw(4'b0010, g0, g1, v0);
    check(g0 == 4'b0010, "R5 sole zero-ticket requester", g0, 4'b0010);

    // R7 hold: owner master 0 keeps the bus while all request
    req = 4'b0011;
    @(negedge clk);
    held = grant0;
    check(held == 4'b0001, "R6 owner before hold", held, 4'b0001);
    req = 4'b1111;
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      check(grant0 == held && gv0, "R7 grant held", grant0, held);
    end
    // R8: owner drops, masters 1..3 remain; counts 0,3,4 -> master 2 or 3
    req = 4'b1110;
    @(negedge clk);
    check(grant0 == 4'b0100 || grant0 == 4'b1000, "R8 re-draw after release", grant0, 4'b1100);
    // R3: everybody drops
    req = 4'b0000;
    @(negedge clk);
    check(grant0 == '0 && !gv0, "R3 no requesters no grant", {gv0, grant0}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule